// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block performs the hardware part of taking an interrupt in a small processor core. There are two request classes, a normal request and a fast request. Each one arrives on its own active-low line. The block holds the current status word. The core tells it when an instruction has completed and which address comes next. When a request is unmasked and an instruction completes, the block switches the status word into the matching exception mode and sets the mask bits for that mode. In the same clock edge it stores the old status word and the return address in that mode's banked registers. During the next cycle it presents the vector address for the core to fetch from.

The return path works from a return strobe. If the current mode is one of the two exception modes, the strobe copies that mode's saved status back into the current status word. The core can also load the status word directly, for example to clear the mask bits after reset.

The sequencer has four states, and each one lasts a single cycle:
- `ST_RUN`: no action took place.
- `ST_IRQ_ENT`: a normal entry took place.
- `ST_FIQ_ENT`: a fast entry took place.
- `ST_RESTORE`: a return restored the status.

The next state is chosen from the inputs on every edge, whatever the current state is:
- fast take goes to `ST_FIQ_ENT`;
- otherwise, normal take goes to `ST_IRQ_ENT`;
- otherwise, a valid return goes to `ST_RESTORE`;
- otherwise, the next state is `ST_RUN`.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word is zero except mode field [4:0] = RST_MODE (default 5'b10011) and mask bits 7 and 6 both set. The banked return-address and saved-status registers are zero, `entry_taken` is 0 and `vec_addr` is 0.
- R2: Both request lines are active low. A line held high never causes an entry.
- R3: An entry happens only at an edge where `insn_done` is high. `entry_taken` is high for exactly the one cycle that follows that edge.
- R4: A normal request is ignored while status bit 7 is set. A fast request is ignored while status bit 6 is set. An ignored request leaves the status and banked registers unchanged.
- R5: On normal entry the mode field becomes 5'b10010 and bit 7 is set. Bit 6 and all other bits keep their values. The normal saved-status register receives the previous status word.
- R6: On fast entry the mode field becomes 5'b10001 and bits 7 and 6 are both set. All other bits keep their values. The fast saved-status register receives the previous status word.
- R7: The return-address register of the entered mode receives `next_pc + 4`, modulo 2^ADDR_W. The other mode's return-address register is unchanged.
- R8: When both requests can be taken at the same edge, the fast one is taken. The normal one stays pending.
- R9: While `entry_taken` is high, `vec_addr` is VEC_BASE+0x18 for a normal entry and VEC_BASE+0x1C for a fast entry, and `entry_fast` tells the two apart. At other times `vec_addr` is 0.
- R10: A return strobe in mode 5'b10010 restores the normal saved status into the status word. In mode 5'b10001 it restores the fast saved status. In any other mode it has no effect. If an entry is taken at the same edge, the entry wins and the return is dropped.
- R11: `psr_wr_en` loads `psr_wr_data` into the status word only when no entry and no restore happens at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | 1 | Normal interrupt request, active low |
| fiq_n | input | 1 | Fast interrupt request, active low |
| insn_done | input | 1 | Current instruction has completed |
| next_pc | input | ADDR_W | Address of the next instruction |
| eret | input | 1 | Return-from-exception strobe |
| psr_wr_en | input | 1 | Direct status-word load enable |
| psr_wr_data | input | PSR_W | Value for the direct status-word load |
| cpsr | output | PSR_W | Current status word |
| lr_irq | output | ADDR_W | Normal-mode return address |
| spsr_irq | output | PSR_W | Normal-mode saved status |
| lr_fiq | output | ADDR_W | Fast-mode return address |
| spsr_fiq | output | PSR_W | Fast-mode saved status |
| entry_taken | output | 1 | One-cycle pulse after an entry |
| entry_fast | output | 1 | The pulsing entry was fast |
| vec_addr | output | ADDR_W | Vector fetch address during the pulse |

## Verification
The bench builds the block with ADDR_W=16, PSR_W=12 and VEC_BASE=16'hFF00.

The 16-bit address width brings the return-address wraparound at 16'hFFFC into reach. The 12-bit status word leaves four upper bits that every entry must carry through unchanged.

The bench sweeps all 32 combinations of the two request lines, the two mask bits and the completion strobe. Each step is followed by a return. Directed steps then cover nested fast-over-normal entry, a return that collides with an entry, and a direct load that collides with an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_IRQ_ENT,
        ST_FIQ_ENT,
        ST_RESTORE
    } exc_state_e;

    localparam logic [4:0] MODE_IRQ     = 5'b10010;
    localparam logic [4:0] MODE_FIQ     = 5'b10001;
    localparam int         IRQ_MASK_BIT = 7;
    localparam int         FIQ_MASK_BIT = 6;
    localparam int         IRQ_VEC_OFS  = 24;
    localparam int         FIQ_VEC_OFS  = 28;
    localparam int         BANK_IRQ     = 0;
    localparam int         BANK_FIQ     = 1;
    localparam int         NUM_BANKS    = 2;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter (
    input  logic irq_n,
    input  logic fiq_n,
    input  logic insn_done,
    input  logic irq_masked,
    input  logic fiq_masked,
    output logic take_irq,
    output logic take_fiq
);
    logic irq_live;
    logic fiq_live;

    always_comb begin
        irq_live = !irq_n && !irq_masked;
        fiq_live = !fiq_n && !fiq_masked;
        take_fiq = insn_done && fiq_live;
        take_irq = insn_done && irq_live && !fiq_live;
    end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_irq,
    input  logic take_fiq,
    input  logic ret_ok,
    output logic do_irq,
    output logic do_fiq,
    output logic do_ret,
    output logic entry_taken,
    output logic entry_fast
);
    exc_state_e state_q;
    exc_state_e state_d;

    always_comb begin
        if (take_fiq)      state_d = ST_FIQ_ENT;
        else if (take_irq) state_d = ST_IRQ_ENT;
        else if (ret_ok)   state_d = ST_RESTORE;
        else               state_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        do_irq = (state_d == ST_IRQ_ENT);
        do_fiq = (state_d == ST_FIQ_ENT);
        do_ret = (state_d == ST_RESTORE);
        entry_taken = 1'b0;
        entry_fast  = 1'b0;
        unique case (state_q)
            ST_RUN:     ;
            ST_IRQ_ENT: entry_taken = 1'b1;
            ST_FIQ_ENT: begin
                entry_taken = 1'b1;
                entry_fast  = 1'b1;
            end
            ST_RESTORE: ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
    parameter int ADDR_W = 32,
    parameter int PSR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [PSR_W-1:0]  old_psr,
    output logic [ADDR_W-1:0] lr,
    output logic [PSR_W-1:0]  spsr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr   <= '0;
            spsr <= '0;
        end else if (we) begin
            lr   <= ret_addr;
            spsr <= old_psr;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter int               PSR_W    = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0,
    parameter logic [4:0]       RST_MODE = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic              fiq_n,
    input  logic              insn_done,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              eret,
    input  logic              psr_wr_en,
    input  logic [PSR_W-1:0]  psr_wr_data,
    output logic [PSR_W-1:0]  cpsr,
    output logic [ADDR_W-1:0] lr_irq,
    output logic [PSR_W-1:0]  spsr_irq,
    output logic [ADDR_W-1:0] lr_fiq,
    output logic [PSR_W-1:0]  spsr_fiq,
    output logic              entry_taken,
    output logic              entry_fast,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam logic [ADDR_W-1:0] RET_OFS  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] IRQ_VEC  = VEC_BASE + ADDR_W'(IRQ_VEC_OFS);
    localparam logic [ADDR_W-1:0] FIQ_VEC  = VEC_BASE + ADDR_W'(FIQ_VEC_OFS);

    logic [PSR_W-1:0] cpsr_q;
    logic             take_irq, take_fiq, ret_ok;
    logic             do_irq, do_fiq, do_ret;
    logic [4:0]       cur_mode;
    logic [PSR_W-1:0] irq_psr, fiq_psr, ret_psr, rst_psr;
    logic [NUM_BANKS-1:0] bank_we;
    logic [ADDR_W-1:0]    bank_lr   [NUM_BANKS];
    logic [PSR_W-1:0]     bank_spsr [NUM_BANKS];
    logic [ADDR_W-1:0]    ret_addr;

    assign cur_mode = cpsr_q[4:0];
    assign ret_addr = next_pc + RET_OFS;

    exc_arbiter u_arb (
        .irq_n      (irq_n),
        .fiq_n      (fiq_n),
        .insn_done  (insn_done),
        .irq_masked (cpsr_q[IRQ_MASK_BIT]),
        .fiq_masked (cpsr_q[FIQ_MASK_BIT]),
        .take_irq   (take_irq),
        .take_fiq   (take_fiq)
    );

    assign ret_ok = eret && (cur_mode == MODE_IRQ || cur_mode == MODE_FIQ);

    exc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_irq    (take_irq),
        .take_fiq    (take_fiq),
        .ret_ok      (ret_ok),
        .do_irq      (do_irq),
        .do_fiq      (do_fiq),
        .do_ret      (do_ret),
        .entry_taken (entry_taken),
        .entry_fast  (entry_fast)
    );

    assign bank_we[BANK_IRQ] = do_irq;
    assign bank_we[BANK_FIQ] = do_fiq;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            exc_bank #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (bank_we[b]),
                .ret_addr (ret_addr),
                .old_psr  (cpsr_q),
                .lr       (bank_lr[b]),
                .spsr     (bank_spsr[b])
            );
        end
    endgenerate

    always_comb begin
        rst_psr = '0;
        rst_psr[IRQ_MASK_BIT] = 1'b1;
        rst_psr[FIQ_MASK_BIT] = 1'b1;
        rst_psr[4:0] = RST_MODE;

        irq_psr = cpsr_q;
        irq_psr[IRQ_MASK_BIT] = 1'b1;
        irq_psr[4:0] = MODE_IRQ;

        fiq_psr = cpsr_q;
        fiq_psr[IRQ_MASK_BIT] = 1'b1;
        fiq_psr[FIQ_MASK_BIT] = 1'b1;
        fiq_psr[4:0] = MODE_FIQ;

        ret_psr = (cur_mode == MODE_FIQ) ? bank_spsr[BANK_FIQ] : bank_spsr[BANK_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cpsr_q <= rst_psr;
        else if (do_fiq)    cpsr_q <= fiq_psr;
        else if (do_irq)    cpsr_q <= irq_psr;
        else if (do_ret)    cpsr_q <= ret_psr;
        else if (psr_wr_en) cpsr_q <= psr_wr_data;
    end

    assign cpsr     = cpsr_q;
    assign lr_irq   = bank_lr[BANK_IRQ];
    assign spsr_irq = bank_spsr[BANK_IRQ];
    assign lr_fiq   = bank_lr[BANK_FIQ];
    assign spsr_fiq = bank_spsr[BANK_FIQ];
    assign vec_addr = !entry_taken ? '0 : (entry_fast ? FIQ_VEC : IRQ_VEC);
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int PSR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              fiq_n,
    input logic              insn_done,
    input logic [ADDR_W-1:0] next_pc,
    input logic              eret,
    input logic [PSR_W-1:0]  cpsr,
    input logic [ADDR_W-1:0] lr_fiq,
    input logic [PSR_W-1:0]  spsr_irq,
    input logic              entry_taken,
    input logic              entry_fast
);
    logic fiq_ok, irq_ok;
    assign fiq_ok = insn_done && !fiq_n && !cpsr[6];
    assign irq_ok = insn_done && !irq_n && !cpsr[7];

    AST_NO_ENTRY_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |=> !entry_taken); // R3

    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr[7] && cpsr[6]) |=> !entry_taken); // R4

    AST_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_taken && !entry_fast) |-> (cpsr[4:0] == 5'b10010 && cpsr[7])); // R5

    AST_IRQ_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ok && !fiq_ok) |=> spsr_irq == $past(cpsr)); // R5

    AST_FIQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_taken && entry_fast) |-> (cpsr[4:0] == 5'b10001 && cpsr[7] && cpsr[6])); // R6

    AST_FIQ_LR: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_ok |=> lr_fiq == $past(next_pc) + ADDR_W'(4)); // R7

    AST_FIQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_ok && irq_ok) |=> (entry_taken && entry_fast)); // R8

    AST_RET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !fiq_ok && !irq_ok && cpsr[4:0] == 5'b10010) |=> cpsr == $past(spsr_irq)); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_n       (irq_n),
    .fiq_n       (fiq_n),
    .insn_done   (insn_done),
    .next_pc     (next_pc),
    .eret        (eret),
    .cpsr        (cpsr),
    .lr_fiq      (lr_fiq),
    .spsr_irq    (spsr_irq),
    .entry_taken (entry_taken),
    .entry_fast  (entry_fast)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
    localparam int           AW       = 16;
    localparam int           PW       = 12;
    localparam logic [AW-1:0] BASE    = 16'hFF00;
    localparam int           CLK_PER  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_n = 1'b1, fiq_n = 1'b1, insn_done = 1'b0, eret = 1'b0, psr_wr_en = 1'b0;
    logic [AW-1:0] next_pc = '0;
    logic [PW-1:0] psr_wr_data = '0;
    logic [PW-1:0] cpsr, spsr_irq, spsr_fiq;
    logic [AW-1:0] lr_irq, lr_fiq, vec_addr;
    logic entry_taken, entry_fast;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [PW-1:0] m_cpsr, m_sirq, m_sfiq;
    logic [AW-1:0] m_lirq, m_lfiq;

    exc_entry_seq #(.ADDR_W(AW), .PSR_W(PW), .VEC_BASE(BASE)) u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fiq_n(fiq_n),
        .insn_done(insn_done), .next_pc(next_pc), .eret(eret),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
        .cpsr(cpsr), .lr_irq(lr_irq), .spsr_irq(spsr_irq),
        .lr_fiq(lr_fiq), .spsr_fiq(spsr_fiq),
        .entry_taken(entry_taken), .entry_fast(entry_fast), .vec_addr(vec_addr)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic irqn, input logic fiqn, input logic done, input logic er,
                       input logic wr, input logic [PW-1:0] wd, input logic [AW-1:0] npc);
        logic ft, it, fl, il;
        logic exp_t, exp_f;
        logic [AW-1:0] exp_v;
        string ttag, ptag;
        fl = !fiqn && !m_cpsr[6];
        il = !irqn && !m_cpsr[7];
        ft = done && fl;
        it = done && il && !fl;
        irq_n = irqn; fiq_n = fiqn; insn_done = done; eret = er;
        psr_wr_en = wr; psr_wr_data = wd; next_pc = npc;
        exp_t = ft || it; exp_f = ft;
        exp_v = ft ? BASE + 16'h1C : (it ? BASE + 16'h18 : 16'h0);
        if (!done) ttag = "R3";
        else if (irqn && fiqn) ttag = "R2";
        else if (fl && il) ttag = "R8";
        else if (!ft && !it) ttag = "R4";
        else ttag = "R3";
        if (ft) begin
            m_sfiq = m_cpsr; m_lfiq = npc + 16'd4;
            m_cpsr[7] = 1'b1; m_cpsr[6] = 1'b1; m_cpsr[4:0] = 5'b10001; ptag = "R6";
        end else if (it) begin
            m_sirq = m_cpsr; m_lirq = npc + 16'd4;
            m_cpsr[7] = 1'b1; m_cpsr[4:0] = 5'b10010; ptag = "R5";
        end else if (er && m_cpsr[4:0] == 5'b10010) begin
            m_cpsr = m_sirq; ptag = "R10";
        end else if (er && m_cpsr[4:0] == 5'b10001) begin
            m_cpsr = m_sfiq; ptag = "R10";
        end else if (wr) begin
            m_cpsr = wd; ptag = "R11";
        end else ptag = er ? "R10" : "R4";
        @(posedge clk);
        @(negedge clk);
        irq_n = 1'b1; fiq_n = 1'b1; insn_done = 1'b0; eret = 1'b0; psr_wr_en = 1'b0;
        chk(ttag, "entry_taken", 32'(entry_taken), 32'(exp_t));
        chk("R9", "entry_fast", 32'(entry_fast), 32'(exp_f));
        chk("R9", "vec_addr", 32'(vec_addr), 32'(exp_v));
        chk(ptag, "cpsr", 32'(cpsr), 32'(m_cpsr));
        chk("R5", "spsr_irq", 32'(spsr_irq), 32'(m_sirq));
        chk("R6", "spsr_fiq", 32'(spsr_fiq), 32'(m_sfiq));
        chk("R7", "lr_irq", 32'(lr_irq), 32'(m_lirq));
        chk("R7", "lr_fiq", 32'(lr_fiq), 32'(m_lfiq));
        // the pulse must not linger: idle cycle after any step
        @(posedge clk);
        @(negedge clk);
        chk("R3", "pulse_width", 32'(entry_taken), 32'd0);
        chk("R9", "vec_idle", 32'(vec_addr), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_cpsr = 12'h0D3; m_sirq = '0; m_sfiq = '0; m_lirq = '0; m_lfiq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cpsr", 32'(cpsr), 32'h0D3);
        chk("R1", "entry_taken", 32'(entry_taken), 32'd0);
        chk("R1", "vec_addr", 32'(vec_addr), 32'd0);
        chk("R1", "lr_irq", 32'(lr_irq), 32'd0);
        chk("R1", "lr_fiq", 32'(lr_fiq), 32'd0);
        chk("R1", "spsr_irq", 32'(spsr_irq), 32'd0);
        chk("R1", "spsr_fiq", 32'(spsr_fiq), 32'd0);

        // sweep: irq_n, fiq_n, mask7, mask6, insn_done
        for (int c = 0; c < 32; c++) begin
            logic [PW-1:0] wd;
            logic [AW-1:0] npc;
            wd = {4'(c[3:0] ^ 4'h5), c[2], c[3], 1'b0, 5'b10011};
            npc = (c == 31) ? 16'hFFFC : 16'(16'h1000 + c * 4);
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, wd, 16'h0);
            cyc(c[0], c[1], c[4], 1'b0, 1'b0, '0, npc);
            cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 16'h0);
        end

        // nested: normal entry then fast entry while normal still pending
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'hA13, 16'h0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 16'h2000);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 16'h2100);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 16'h0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 16'h0);
        // return colliding with fast entry: entry wins
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 16'h3000);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, 16'h3004);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 16'h0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 16'h0);
        // direct load colliding with an entry: entry wins
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 12'h010, 16'h4000);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 16'h0);
        // return in a non-exception mode is ignored
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'h0D0, 16'h0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 16'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule